// File: doc/BRIEF.md
# Processor Halt and Bus-Status Pin Controller

This block sits beside a small 8-bit processor core and drives the core's external status pins. Microcode strobes from the core tell it when a read-modify-write sequence begins and ends, and when an interrupt vector address is being fetched. From these it drives an active-low bus-lock output and an active-low vector-fetch indicator. It also watches the set-overflow input. On each falling edge of that input it sends a one-cycle active-low preset pulse to the core's overflow flag.

The block also owns the two halt instructions. A wait-for-interrupt halt stops the internal clock through a clock-enable output and pulls the shared ready line low. Any interrupt or reset resumes the core from it. A full stop halts the clock only and leaves the ready line alone. Only reset resumes the core from a full stop. The bus is never released to the high-impedance state by either halt. Instead, lock, vector-fetch and read/write are all forced high while the core is halted. An external ready line held low also freezes the clock.

Top module: `halt_bus_status`

## Requirements
- R1: While `resN` is sampled low at a clock edge, the block returns to the running state with the lock released and no preset pulse pending. After that edge `clkEn` equals `rdyIn`, `rdyPullLow` is 0, `mlN` is 1 and `vPresetN` is 1.
- R2: When `soN` is sampled low at an edge after being sampled high at the previous edge, `vPresetN` is 0 for exactly the one cycle following that edge. A held-low or rising `soN` produces no pulse.
- R3: At an edge where `clkEn` is 1, `rmwReadStb` sets the lock and `endInstrStb` clears it. If both are high, the set wins. `mlN` is the inverse of the lock while running.
- R4: `vpN` is 0 exactly when `vecSelA` and `vecSelB` are both 1 and the core is not halted. It responds in the same cycle.
- R5: `waiStb` accepted at an edge (with `clkEn`=1 and no `stpStb`) enters the wait halt. From the next cycle `rdyPullLow` is 1 and `clkEn` is 0.
- R6: In the wait halt, an edge sampling `irqN` or `nmiN` low returns the core to running in the following cycle, releasing `rdyPullLow`.
- R7: `stpStb` accepted at an edge enters the stop halt. There `clkEn` is 0 and `rdyPullLow` stays 0. `irqN` and `nmiN` have no effect, and only `resN` leaves the stop halt.
- R8: While either halt is active, `mlN`, `vpN` and `rwOut` are all 1. Otherwise `rwOut` follows `coreRw`.
- R9: `clkEn` is 0 whenever `rdyIn` is 0. At such an edge, `rmwReadStb`, `endInstrStb`, `stpStb` and `waiStb` are ignored.
- R10: When `stpStb` and `waiStb` are accepted at the same edge, the stop halt is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-2 clock; all state changes on its rising edge |
| resN | input | 1 | Active-low reset, sampled synchronously; also the only wake from stop |
| rdyIn | input | 1 | External ready line level; low freezes the core clock |
| rmwReadStb | input | 1 | Microcode strobe: read cycle of a read-modify-write sequence |
| endInstrStb | input | 1 | Microcode strobe: end of instruction (next opcode fetch) |
| vecSelA | input | 1 | Microcode vector-constant select, first term |
| vecSelB | input | 1 | Microcode vector-constant select, second term |
| stpStb | input | 1 | Microcode strobe: stop instruction |
| waiStb | input | 1 | Microcode strobe: wait-for-interrupt instruction |
| irqN | input | 1 | Maskable interrupt request, active low |
| nmiN | input | 1 | Non-maskable interrupt request, active low |
| soN | input | 1 | Set-overflow input, falling edge active |
| coreRw | input | 1 | Read/write level from the core (1 = read) |
| clkEn | output | 1 | Core clock enable; 0 holds the core in its high phase |
| rdyPullLow | output | 1 | 1 turns on the open-drain pull-down of the ready line |
| mlN | output | 1 | Bus lock, active low |
| vpN | output | 1 | Vector fetch indicator, active low |
| rwOut | output | 1 | Read/write pin level, forced to read while halted |
| vPresetN | output | 1 | Overflow-flag preset pulse, active low |

## Verification
The embedded properties assume that `resN` is held low across at least one rising edge before anything else happens. They also assume that every input is stable around each rising edge, because they reason only about sampled values. The interrupt-wake and stop-hold properties take reset as the sole exit from the stop halt. They therefore make no claim about cycles in which `resN` is low. The stimulus changes inputs only on the falling clock edge and opens with a reset. A randomized phase pulses reset rarely, so long stretches of stop, wait and external-ready stalls are visited between resets.

// File: rtl/halt_pkg.sv
package halt_pkg;

  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_WAIT = 2'd1,
    HS_STOP = 2'd2
  } haltState_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic halted;   // any halt instruction active
    logic advance;  // core clock enabled this cycle; microcode strobes valid
  } ctlStrobes_t;

endpackage

// File: rtl/halt_ctrl.sv
module halt_ctrl
  import halt_pkg::*;
(
  input  logic        clk,
  input  logic        resN,
  input  logic        rdyIn,
  input  logic        stpStb,
  input  logic        waiStb,
  input  logic        irqN,
  input  logic        nmiN,
  output logic        clkEn,
  output logic        rdyPullLow,
  output ctlStrobes_t ctlOut
);

  haltState_e state, stateNext;
  logic       running;
  logic       anyIrq;

  assign running = (state == HS_RUN);
  assign anyIrq  = ~irqN | ~nmiN;

  // Gating: internal halt and external ready both stall the clock
  assign clkEn      = running & rdyIn;
  assign rdyPullLow = (state == HS_WAIT);

  assign ctlOut.halted  = ~running;
  assign ctlOut.advance = clkEn;

  always_comb begin
    stateNext = state;
    unique case (state)
      HS_RUN: begin
        if (clkEn && stpStb)      stateNext = HS_STOP;
        else if (clkEn && waiStb) stateNext = HS_WAIT;
      end
      HS_WAIT: if (anyIrq) stateNext = HS_RUN;
      HS_STOP: stateNext = HS_STOP;
      default: stateNext = HS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!resN) state <= HS_RUN;
    else       state <= stateNext;
  end

  // R5
  wai_enter_chk: assert property (@(posedge clk) disable iff (!resN)
    (clkEn && waiStb && !stpStb) |=> (rdyPullLow && !clkEn));

  // R6
  wai_wake_chk: assert property (@(posedge clk) disable iff (!resN)
    (rdyPullLow && (!irqN || !nmiN)) |=> !rdyPullLow && !ctlOut.halted);

  // R7
  stp_hold_chk: assert property (@(posedge clk) disable iff (!resN)
    (state == HS_STOP) |=> (state == HS_STOP && !clkEn && !rdyPullLow));

  // R9
  rdy_stall_chk: assert property (@(posedge clk) disable iff (!resN)
    (!rdyIn && running) |=> running);

  // R10
  stp_prio_chk: assert property (@(posedge clk) disable iff (!resN)
    (clkEn && stpStb && waiStb) |=> (ctlOut.halted && !rdyPullLow));

endmodule

// File: rtl/status_pins.sv
module status_pins
  import halt_pkg::*;
#(
  parameter bit LOCK_SET_WINS = 1'b1
) (
  input  logic        clk,
  input  logic        resN,
  input  ctlStrobes_t ctlIn,
  input  logic        rmwReadStb,
  input  logic        endInstrStb,
  input  logic        vecSelA,
  input  logic        vecSelB,
  input  logic        coreRw,
  input  logic        soN,
  output logic        mlN,
  output logic        vpN,
  output logic        rwOut,
  output logic        vPresetN
);

  logic lockQ, lockNext;
  logic soPrevQ;
  logic presetQ;
  logic setEn, clrEn;

  assign setEn = ctlIn.advance & rmwReadStb;
  assign clrEn = ctlIn.advance & endInstrStb;

  generate
    if (LOCK_SET_WINS) begin : g_setWins
      always_comb begin
        lockNext = lockQ;
        if (clrEn) lockNext = 1'b0;
        if (setEn) lockNext = 1'b1;
      end
    end else begin : g_clrWins
      always_comb begin
        lockNext = lockQ;
        if (setEn) lockNext = 1'b1;
        if (clrEn) lockNext = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!resN) begin
      lockQ   <= 1'b0;
      soPrevQ <= 1'b1;
      presetQ <= 1'b0;
    end else begin
      lockQ   <= lockNext;
      soPrevQ <= soN;
      presetQ <= soPrevQ & ~soN;
    end
  end

  assign mlN      = ~lockQ | ctlIn.halted;
  assign vpN      = ~(vecSelA & vecSelB) | ctlIn.halted;
  assign rwOut    = coreRw | ctlIn.halted;
  assign vPresetN = ~presetQ;

  // R8
  halted_pins_chk: assert property (@(posedge clk) disable iff (!resN)
    ctlIn.halted |-> (mlN && vpN && rwOut));

  // R2
  preset_single_chk: assert property (@(posedge clk) disable iff (!resN)
    !vPresetN |=> vPresetN);

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!resN)
    (lockQ && !(ctlIn.advance && endInstrStb)) |=> lockQ);

  // R3
  lock_set_chk: assert property (@(posedge clk) disable iff (!resN)
    (ctlIn.advance && rmwReadStb) |=> lockQ);

endmodule

// File: rtl/halt_bus_status.sv
module halt_bus_status
  import halt_pkg::*;
#(
  parameter bit LOCK_SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic resN,
  input  logic rdyIn,
  input  logic rmwReadStb,
  input  logic endInstrStb,
  input  logic vecSelA,
  input  logic vecSelB,
  input  logic stpStb,
  input  logic waiStb,
  input  logic irqN,
  input  logic nmiN,
  input  logic soN,
  input  logic coreRw,
  output logic clkEn,
  output logic rdyPullLow,
  output logic mlN,
  output logic vpN,
  output logic rwOut,
  output logic vPresetN
);

  ctlStrobes_t ctlBus;

  halt_ctrl ctrl_i (
    .clk        (clk),
    .resN       (resN),
    .rdyIn      (rdyIn),
    .stpStb     (stpStb),
    .waiStb     (waiStb),
    .irqN       (irqN),
    .nmiN       (nmiN),
    .clkEn      (clkEn),
    .rdyPullLow (rdyPullLow),
    .ctlOut     (ctlBus)
  );

  status_pins #(.LOCK_SET_WINS(LOCK_SET_WINS)) pins_i (
    .clk         (clk),
    .resN        (resN),
    .ctlIn       (ctlBus),
    .rmwReadStb  (rmwReadStb),
    .endInstrStb (endInstrStb),
    .vecSelA     (vecSelA),
    .vecSelB     (vecSelB),
    .coreRw      (coreRw),
    .soN         (soN),
    .mlN         (mlN),
    .vpN         (vpN),
    .rwOut       (rwOut),
    .vPresetN    (vPresetN)
  );

endmodule

// File: tb/halt_bus_status_tb.sv
`timescale 1ns/1ps
module halt_bus_status_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic resN = 1'b0, rdyIn = 1'b1, rmwReadStb = 1'b0, endInstrStb = 1'b0;
  logic vecSelA = 1'b0, vecSelB = 1'b0, stpStb = 1'b0, waiStb = 1'b0;
  logic irqN = 1'b1, nmiN = 1'b1, soN = 1'b1, coreRw = 1'b1;
  logic clkEn, rdyPullLow, mlN, vpN, rwOut, vPresetN;

  halt_bus_status dut_i (
    .clk(clk), .resN(resN), .rdyIn(rdyIn), .rmwReadStb(rmwReadStb),
    .endInstrStb(endInstrStb), .vecSelA(vecSelA), .vecSelB(vecSelB),
    .stpStb(stpStb), .waiStb(waiStb), .irqN(irqN), .nmiN(nmiN), .soN(soN),
    .coreRw(coreRw), .clkEn(clkEn), .rdyPullLow(rdyPullLow), .mlN(mlN),
    .vpN(vpN), .rwOut(rwOut), .vPresetN(vPresetN)
  );

  // Behavioural reference: 0 = running, 1 = waiting, 2 = stopped
  int mState = 0;
  bit mLock = 0, mSoPrev = 1, mPulse = 0;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always @(posedge clk) begin
    bit go;
    go = (mState == 0) && rdyIn;
    if (!resN) begin
      mState = 0; mLock = 0; mSoPrev = 1; mPulse = 0;
    end else begin
      mPulse  = mSoPrev && !soN;
      mSoPrev = soN;
      if (go && rmwReadStb)       mLock = 1;
      else if (go && endInstrStb) mLock = 0;
      case (mState)
        0: if (go && stpStb) mState = 2; else if (go && waiStb) mState = 1;
        1: if (!irqN || !nmiN) mState = 0;
        default: mState = 2;
      endcase
    end
  end

  task automatic chk(string tag, string nm, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit halted;
    halted = (mState != 0);
    chk("R9", "clkEn", clkEn, (mState == 0) && rdyIn);
    chk("R5", "rdyPullLow", rdyPullLow, mState == 1);
    chk("R3", "mlN", mlN, !mLock || halted);
    chk("R4", "vpN", vpN, !(vecSelA && vecSelB) || halted);
    chk("R8", "rwOut", rwOut, coreRw || halted);
    chk("R2", "vPresetN", vPresetN, !mPulse);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic clearStb();
    rmwReadStb = 0; endInstrStb = 0; stpStb = 0; waiStb = 0;
    vecSelA = 0; vecSelB = 0;
  endtask

  initial begin
    // R1: reset state
    cyc(2);
    chk("R1", "rdyPullLow", rdyPullLow, 1'b0);
    chk("R1", "mlN", mlN, 1'b1);
    chk("R1", "vPresetN", vPresetN, 1'b1);
    resN = 1; cyc(2);

    // R2: falling edge, held low, rising
    soN = 0; cyc(1);
    chk("R2", "pulse", vPresetN, 1'b0);
    cyc(3);
    chk("R2", "held low", vPresetN, 1'b1);
    soN = 1; cyc(2); soN = 0; cyc(1); soN = 1; cyc(2);

    // R3: RMW lock sequence, then set and clear together
    coreRw = 1; rmwReadStb = 1; cyc(1);
    chk("R3", "lock set", mlN, 1'b0);
    rmwReadStb = 0; coreRw = 0; cyc(2);
    coreRw = 1; endInstrStb = 1; cyc(1);
    chk("R3", "lock clear", mlN, 1'b1);
    rmwReadStb = 1; cyc(1);
    chk("R3", "set wins", mlN, 1'b0);
    clearStb(); endInstrStb = 1; cyc(1); clearStb();

    // R4: vector fetch decode
    vecSelA = 1; cyc(1); vecSelB = 1; cyc(1);
    chk("R4", "vector", vpN, 1'b0);
    vecSelA = 0; cyc(1); clearStb();

    // R9: external ready low ignores strobes
    rdyIn = 0; rmwReadStb = 1; waiStb = 1; stpStb = 1; cyc(1);
    clearStb(); cyc(1);
    chk("R9", "no lock", mlN, 1'b1);
    chk("R9", "no halt", rdyPullLow, 1'b0);
    rdyIn = 1; cyc(1);

    // R5/R6: wait, wake by irq; then wait, wake by nmi
    rmwReadStb = 1; cyc(1); clearStb();
    waiStb = 1; cyc(1); clearStb(); coreRw = 0; vecSelA = 1; vecSelB = 1;
    chk("R5", "wait rdy", rdyPullLow, 1'b1);
    chk("R8", "ml forced", mlN, 1'b1);
    cyc(4);
    irqN = 0; cyc(1); irqN = 1;
    chk("R6", "irq wake", rdyPullLow, 1'b0);
    clearStb(); cyc(1);
    waiStb = 1; cyc(1); clearStb(); cyc(3);
    nmiN = 0; cyc(1); nmiN = 1;
    chk("R6", "nmi wake", clkEn, 1'b1);
    endInstrStb = 1; cyc(1); clearStb();

    // R7/R10: stop beats wait, ignores interrupts, leaves via reset
    stpStb = 1; waiStb = 1; cyc(1); clearStb();
    chk("R10", "stop chosen", rdyPullLow, 1'b0);
    irqN = 0; nmiN = 0; cyc(4);
    chk("R7", "stays stopped", clkEn, 1'b0);
    irqN = 1; nmiN = 1;
    resN = 0; cyc(1); resN = 1;
    chk("R7", "reset wakes", clkEn, 1'b1);
    coreRw = 1; cyc(2);

    // R11-style reset from wait and with lock held (covered by R1)
    rmwReadStb = 1; cyc(1); clearStb(); waiStb = 1; cyc(1); clearStb();
    resN = 0; cyc(1); resN = 1;
    chk("R1", "reset clears", mlN, 1'b1);
    cyc(1);

    // Randomized phase, all requirements through the model
    for (int k = 0; k < 4000; k++) begin
      resN        = ($urandom_range(0, 63) != 0);
      rdyIn       = ($urandom_range(0, 7) != 0);
      rmwReadStb  = ($urandom_range(0, 7) == 0);
      endInstrStb = ($urandom_range(0, 7) == 0);
      stpStb      = ($urandom_range(0, 31) == 0);
      waiStb      = ($urandom_range(0, 15) == 0);
      irqN        = ($urandom_range(0, 7) != 0);
      nmiN        = ($urandom_range(0, 15) != 0);
      vecSelA     = $urandom_range(0, 1);
      vecSelB     = $urandom_range(0, 1);
      soN         = $urandom_range(0, 1);
      coreRw      = $urandom_range(0, 1);
      cyc(1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule